// File: doc/BRIEF.md
# Input Change Monitor with Deferred Interrupt

This block watches four asynchronous input pins and keeps a sticky change flag for each one. After a two-flop synchronizer, each input is compared with a snapshot register. Any difference sets that input's flag, and the flag stays set until the next snapshot. A 4-bit mask picks which flags may drive the interrupt. The interrupt is an open-drain enable, `intDrive`. It is high when the pin is pulled low and low when the pin is released.

A bus slave next to this block sends single-cycle strobes. `addrAck` marks the address acknowledge of any access to this port group, with `isRead` qualifying it. `pairAck` marks the start of each further port/flag byte pair during a long read. `flagSent` marks that the flag byte went out, and `stopSeen` marks the STOP condition. On an address acknowledge, or on a pair acknowledge while a read is open, the block takes a fresh snapshot and clears the flags. On a read, it first copies the flags it is about to clear into `flagReport`, so that the flag byte carries the earlier state.

While a read is open, no new interrupt is raised. At STOP, the interrupt is raised for changes that were never reported. It is not raised for changes that were already sent out in a flag byte.

Top module: `input_change_monitor`

## Requirements
- R1: A flag bit is set when the synchronized input differs from its snapshot bit. A pin change applied between clock edges shows in `changeFlags` after the third following rising edge, and not after the second.
- R2: A set flag stays set if the pin returns to its earlier level. Only a snapshot event clears it.
- R3: Flags are set whatever the mask is. Mask bit i (bit i of `maskIn`, written on `maskWe`) lets flag i raise `intDrive`. A flag that is masked off leaves `intDrive` low.
- R4: After reset, the mask is 4'b1111, `changeFlags` and `flagReport` are 0, and `intDrive` is 0. Pin levels held steady through reset set no flag.
- R5: On `addrAck` (read or write), the snapshot is reloaded, all flags clear, and `intDrive` is 0 after that edge.
- R6: On `addrAck` with `isRead`, `flagReport` takes the flag value from before the clear.
- R7: During an open read, `pairAck` retakes the snapshot, clears the flags, and loads `flagReport` with the flags from before the clear.
- R8: A masked change during an open read keeps `intDrive` low until `stopSeen`. After that edge, `intDrive` is 1.
- R9: At STOP, `intDrive` stays low if every masked change was captured at an acknowledge and its flag byte was then sent (`flagSent`). If the flag byte was not sent, `intDrive` goes high at STOP.
- R10: A `stopSeen` with no preceding `addrAck` takes no snapshot, clears no flags, and leaves `intDrive` unchanged.
- R11: Outside a read, a masked flag raises `intDrive` one edge after the flag appears. `intDrive` then stays high until the next `addrAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset to the default state |
| pinIn | input | 4 | Asynchronous monitored inputs |
| addrAck | input | 1 | Strobe: address acknowledge of an access |
| isRead | input | 1 | Qualifies `addrAck` as a read |
| pairAck | input | 1 | Strobe: next port/flag pair begins in a long read |
| flagSent | input | 1 | Strobe: flag byte was sent |
| stopSeen | input | 1 | Strobe: STOP condition |
| maskWe | input | 1 | Mask write enable |
| maskIn | input | 4 | New mask value, bit i for pin i |
| changeFlags | output | 4 | Live sticky change flags |
| flagReport | output | 4 | Flag value captured for the flag byte |
| intDrive | output | 1 | Open-drain pull-down enable, 1 pulls the pin low |

## Verification
Single-pin steps measure the synchronizer and compare latency, down to the exact edge. Pulses that return to the earlier level show that a flag is sticky rather than a copy of the level. Read sequences are varied in three ways: a change before the acknowledge with the flag byte sent, a change before the acknowledge with the flag byte skipped, and a change inside a long read that a pair acknowledge picks up. These show apart the three STOP outcomes: raise the interrupt, keep it low, or raise it for the newer change only. Random pin toggles, mask writes and write accesses, checked against a bench model, separate flag setting from mask gating and show that the interrupt stays high once raised.

// File: rtl/icm_pkg.sv
package icm_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic take;    // reload snapshot, clear flags
    logic report;  // capture pre-clear flags for the flag byte
    logic prime;   // after reset: track inputs, no flagging
  } icmStrobe_t;
endpackage

// File: rtl/icm_datapath.sv
module icm_datapath
  import icm_pkg::*;
#(
  parameter int NUM_IN      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] pinIn,
  input  icmStrobe_t        strobe,
  output logic [NUM_IN-1:0] flags,
  output logic [NUM_IN-1:0] flagReport
);
  logic [NUM_IN-1:0] syncChain [SYNC_STAGES];
  logic [NUM_IN-1:0] syncIn;
  logic [NUM_IN-1:0] snapshot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncChain[s] <= '0;
    end else begin
      syncChain[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
    end
  end

  assign syncIn = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapshot   <= '0;
      flags      <= '0;
      flagReport <= '0;
    end else begin
      if (strobe.report) flagReport <= flags;
      if (strobe.prime || strobe.take) begin
        snapshot <= syncIn;
        flags    <= '0;
      end else begin
        flags <= flags | (syncIn ^ snapshot);
      end
    end
  end

  // R2: flags only fall on a snapshot event
  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.take && !strobe.prime) |=> ((flags & $past(flags)) == $past(flags)));

  // R1: a flag rises only where input and snapshot differed
  a_r1_flag_cause: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(syncIn ^ snapshot)) == '0));

  // R6 / R7: the flag byte holds the pre-clear flags
  a_r6_report_prev: assert property (@(posedge clk) disable iff (!rstN)
    strobe.report |=> (flagReport == $past(flags)));
endmodule

// File: rtl/icm_control.sv
module icm_control
  import icm_pkg::*;
#(
  parameter int NUM_IN      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrAck,
  input  logic              isRead,
  input  logic              pairAck,
  input  logic              flagSent,
  input  logic              stopSeen,
  input  logic              maskWe,
  input  logic [NUM_IN-1:0] maskIn,
  input  logic [NUM_IN-1:0] flags,
  output icmStrobe_t        strobe,
  output logic              intDrive
);
  localparam int PRIME_CYC = SYNC_STAGES + 1;
  localparam int PW        = $clog2(PRIME_CYC + 1);

  logic [NUM_IN-1:0] mask;
  logic [PW-1:0]     primeCnt;
  logic              reading;
  logic              pendHold;
  logic              maskedHit;

  assign maskedHit     = |(flags & mask);
  assign strobe.prime  = (primeCnt != PW'(PRIME_CYC));
  assign strobe.take   = addrAck | (reading & pairAck);
  assign strobe.report = (addrAck & isRead) | (!addrAck & reading & pairAck);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mask     <= '1;
      primeCnt <= '0;
      reading  <= 1'b0;
      pendHold <= 1'b0;
      intDrive <= 1'b0;
    end else begin
      if (strobe.prime) primeCnt <= primeCnt + 1'b1;
      if (maskWe) mask <= maskIn;

      if (addrAck)       reading <= isRead;
      else if (stopSeen) reading <= 1'b0;

      if (strobe.report)            pendHold <= maskedHit;
      else if (stopSeen)            pendHold <= 1'b0;
      else if (reading && flagSent) pendHold <= 1'b0;

      if (strobe.prime || strobe.take) intDrive <= 1'b0;
      else if (stopSeen)               intDrive <= intDrive | maskedHit | pendHold;
      else if (reading)                intDrive <= intDrive;
      else                             intDrive <= intDrive | maskedHit;
    end
  end

  // R5: an address acknowledge releases the interrupt
  a_r5_ack_releases: assert property (@(posedge clk) disable iff (!rstN)
    addrAck |=> !intDrive);

  // R8: no assertion while a read is open
  a_r8_hold_in_read: assert property (@(posedge clk) disable iff (!rstN)
    (reading && !stopSeen) |=> !intDrive);

  // R10: a STOP outside an access never drops the interrupt
  a_r10_stop_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (stopSeen && !reading && !addrAck && intDrive) |=> intDrive);

  // R11: once raised outside a read, it holds until an acknowledge
  a_r11_int_holds: assert property (@(posedge clk) disable iff (!rstN)
    (intDrive && !strobe.take) |=> intDrive);
endmodule

// File: rtl/input_change_monitor.sv
module input_change_monitor
  import icm_pkg::*;
#(
  parameter int NUM_IN      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] pinIn,
  input  logic              addrAck,
  input  logic              isRead,
  input  logic              pairAck,
  input  logic              flagSent,
  input  logic              stopSeen,
  input  logic              maskWe,
  input  logic [NUM_IN-1:0] maskIn,
  output logic [NUM_IN-1:0] changeFlags,
  output logic [NUM_IN-1:0] flagReport,
  output logic              intDrive
);
  icmStrobe_t strobe;

  icm_control #(.NUM_IN(NUM_IN), .SYNC_STAGES(SYNC_STAGES)) uCtl (
    .clk(clk), .rstN(rstN), .addrAck(addrAck), .isRead(isRead),
    .pairAck(pairAck), .flagSent(flagSent), .stopSeen(stopSeen),
    .maskWe(maskWe), .maskIn(maskIn), .flags(changeFlags),
    .strobe(strobe), .intDrive(intDrive)
  );

  icm_datapath #(.NUM_IN(NUM_IN), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .strobe(strobe),
    .flags(changeFlags), .flagReport(flagReport)
  );
endmodule

// File: tb/test_input_change_monitor.sv
module test_input_change_monitor;
  logic clk = 0, rstN = 0;
  logic [3:0] pinIn = 4'b0101, maskIn = '0;
  logic addrAck = 0, isRead = 0, pairAck = 0, flagSent = 0, stopSeen = 0, maskWe = 0;
  logic [3:0] changeFlags, flagReport;
  logic intDrive;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  input_change_monitor i_input_change_monitor (.*);

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(bit rd);
    addrAck = 1; isRead = rd; tick(1); addrAck = 0; isRead = 0;
  endtask

  task automatic pulseStop();
    stopSeen = 1; tick(1); stopSeen = 0;
  endtask

  task automatic setMask(logic [3:0] m);
    maskWe = 1; maskIn = m; tick(1); maskWe = 0;
  endtask

  function automatic logic [3:0] nextFlags(logic [3:0] f, logic [3:0] snap, logic [3:0] p);
    return f | (snap ^ p);
  endfunction

  initial begin
    logic [3:0] expF, snap, msk;
    logic expI;
    void'($urandom(32'd4242));
    tick(3); rstN = 1; tick(5);
    chk("R4 flags", changeFlags, 4'b0000);
    chk("R4 report", flagReport, 4'b0000);
    chk("R4 int", {3'b0, intDrive}, 4'b0000);

    pinIn[0] = ~pinIn[0]; tick(2);
    chk("R1 not yet", changeFlags, 4'b0000);
    tick(1);
    chk("R1 flag", changeFlags, 4'b0001);
    chk("R11 int lag", {3'b0, intDrive}, 4'b0000);
    tick(1);
    chk("R11 int", {3'b0, intDrive}, 4'b0001);
    pinIn[0] = ~pinIn[0]; tick(5);
    chk("R2 sticky", changeFlags, 4'b0001);

    ack(1);
    chk("R5 cleared", changeFlags, 4'b0000);
    chk("R5 released", {3'b0, intDrive}, 4'b0000);
    chk("R6 report", flagReport, 4'b0001);
    pinIn[1] = ~pinIn[1]; tick(6);
    chk("R8 flag in read", changeFlags, 4'b0010);
    chk("R8 held", {3'b0, intDrive}, 4'b0000);
    pulseStop();
    chk("R8 at stop", {3'b0, intDrive}, 4'b0001);

    ack(1);
    chk("R6 report2", flagReport, 4'b0010);
    flagSent = 1; tick(1); flagSent = 0;
    pulseStop(); tick(1);
    chk("R9 reported", {3'b0, intDrive}, 4'b0000);

    pinIn[2] = ~pinIn[2]; tick(5);
    ack(1); tick(2); pulseStop(); tick(1);
    chk("R9 unsent", {3'b0, intDrive}, 4'b0001);

    ack(0);
    chk("R5 write", changeFlags, 4'b0000);
    ack(1);
    pinIn[3] = ~pinIn[3]; tick(5);
    pairAck = 1; tick(1); pairAck = 0;
    chk("R7 report", flagReport, 4'b1000);
    chk("R7 cleared", changeFlags, 4'b0000);
    pinIn[3] = ~pinIn[3]; tick(5);
    chk("R7 new", changeFlags, 4'b1000);
    flagSent = 1; tick(1); flagSent = 0;
    pulseStop();
    chk("R9 newer change", {3'b0, intDrive}, 4'b0001);

    ack(0); setMask(4'b0000);
    pinIn[0] = ~pinIn[0]; tick(5);
    chk("R3 flag unmasked", changeFlags, 4'b0001);
    chk("R3 int off", {3'b0, intDrive}, 4'b0000);
    setMask(4'b0001); tick(1);
    chk("R3 int on", {3'b0, intDrive}, 4'b0001);

    pinIn[0] = ~pinIn[0]; tick(4);
    pulseStop(); tick(2);
    chk("R10 flags kept", changeFlags, 4'b0001);
    chk("R10 int kept", {3'b0, intDrive}, 4'b0001);

    ack(0); setMask(4'b1111);
    expF = 0; snap = pinIn; msk = 4'b1111; expI = 0;
    for (int it = 0; it < 80; it++) begin
      int unsigned r;
      r = $urandom;
      case (r % 4)
        0: begin ack(0); expF = 0; snap = pinIn; expI = 0; end
        1: begin msk = 4'($urandom); setMask(msk); end
        default: begin pinIn = pinIn ^ 4'($urandom); end
      endcase
      tick(5);
      expF = nextFlags(expF, snap, pinIn);
      expI = expI | (|(expF & msk));
      chk("R1 R3 random flags", changeFlags, expF);
      chk("R11 random int", {3'b0, intDrive}, {3'b0, expI});
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule